// File: doc/BRIEF.md
# Glitch-Free Video Clock Source Selector

This block picks the clock that leaves on the video clock output. There are eight possible sources:

- three synthesized register clocks;
- an external clock;
- the reference;
- the memory clock;
- a constant high level;
- a constant low level ("off").

The output enable can also float the pin. All live sources reach the block as level waveforms that have been sampled in the block's own clock domain, for example a divided clock or a toggle. Each one passes through a two-flop synchronizer before use.

The two select pins also carry serial programming traffic. Because of this, a change on them is only committed after the pins have stayed stable for a watchdog interval. A programming burst therefore never disturbs the running selection.

Oscillator settling is modelled only as a timer. It starts after a committed selection change, and after a pulse that reports that the active register was rewritten. While the timer runs, a fallback clock (the reference or the memory clock) drives the output. Every change of source is glitch-free. The switch leaves the old source only while that source is high. The output is then held high until the new source is high, and only then does the output follow the new source.

Top module: `vclk_selector`

## Requirements
- R1: `vclk_en_o` equals `oe_i` as sampled at the previous rising clock edge. When it is low the output is floated, whatever the other inputs are.
- R2: While `pd_ni` is low, the requested source is the constant high level. Once the switch has completed, `vclk_o` stays high.
- R3: After settling, with `pd_ni` high, the committed select value decodes as follows:
  - 2'b00 selects register clock 0.
  - 2'b01 selects register clock 1.
  - 2'b11 selects register clock 2.
  - 2'b10 selects register clock 2 when `ext_sel_i`=1, and the external clock when `ext_sel_i`=0.
- R4: A change of `sel_i` is committed only after the pins have been unchanged for `SEL_TO` further clock edges, or 2*`SEL_TO` edges when `long_to_i`=1. The commit happens on the edge after that. Any change on the pins restarts the count.
- R5: A commit, or a `reprog_i` pulse, starts a settle interval of `SETTLE` cycles. During it the requested source is the memory clock when `fb_mem_i`=1 and the reference when `fb_mem_i`=0.
- R6: The index of the register clock being requested acts as follows. All ones (4'b1111 by default) substitutes the memory clock. All ones minus one (4'b1110) substitutes the constant low level. Any other value keeps the register clock.
- R7: On a change of source, the output rises or stays high and is held high until the new source's synchronized level is high. It never falls while held.
- R8: A live source reaches `vclk_o` three clock edges after it is sampled: two synchronizer flops and the output flop.
- R9: Reset gives `vclk_en_o`=0, `vclk_o`=1, a committed select of 2'b00 and no settle interval running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; all source levels are sampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Output enable; low floats the video clock |
| pd_ni | input | 1 | Power-down, active low; forces the output high |
| sel_i | input | 2 | Select pins, qualified by the watchdog |
| ext_sel_i | input | 1 | Replaces the external clock with register clock 2 for select 2'b10 |
| fb_mem_i | input | 1 | Fallback choice during settling: 1 memory clock, 0 reference |
| long_to_i | input | 1 | Doubles the select watchdog interval |
| reprog_i | input | 1 | One-cycle pulse: the active register was rewritten |
| idx0_i | input | IDX_W | Index field of register 0 |
| idx1_i | input | IDX_W | Index field of register 1 |
| idx2_i | input | IDX_W | Index field of register 2 |
| reg_clk_i | input | 3 | Levels of the three synthesized register clocks |
| ext_clk_i | input | 1 | External clock level |
| ref_clk_i | input | 1 | Reference clock level |
| mem_clk_i | input | 1 | Memory clock level |
| vclk_o | output | 1 | Video clock output |
| vclk_en_o | output | 1 | Drive enable for the video clock pin |

## Verification
Suppose the watchdog count or the committed select is wrong. The output then moves to the new waveform some cycles early or late, or it never leaves the old source. A bench that predicts the output level on every cycle sees the difference within one half period of the sources involved. A wrong settle counter or fallback bit shows up the same way: the output keeps the reference or memory waveform too long, too briefly, or with the wrong period. A broken switch handshake shows as a low pulse, or as a rising edge while the output should be held high, in the first cycles after a source change.

// File: rtl/vclk_sel_pkg.sv
package vclk_sel_pkg;
   // Source codes; the first LIVE_N are synchronized level inputs.
   typedef enum logic [2:0] {
      SRC_R0   = 3'd0,
      SRC_R1   = 3'd1,
      SRC_R2   = 3'd2,
      SRC_EXT  = 3'd3,
      SRC_REF  = 3'd4,
      SRC_MEM  = 3'd5,
      SRC_HIGH = 3'd6,
      SRC_OFF  = 3'd7
   } src_e;

   localparam int LIVE_N = 6;
endpackage

// File: rtl/vclk_src_sync.sv
module vclk_src_sync #(
   parameter int N      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   logic [STAGES-1:0][N-1:0] st_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q[g] <= '0;
            else         st_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q[g] <= '0;
            else         st_q[g] <= st_q[g-1];
         end
      end
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/vclk_sel_qual.sv
module vclk_sel_qual #(
   parameter int SEL_TO = 16,
   parameter int SETTLE = 40
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sel_i,
   input  logic       long_to_i,
   input  logic       reprog_i,
   output logic [1:0] sel_eff_o,
   output logic       settling_o
);
   localparam int WD_W  = $clog2(2 * SEL_TO + 1);
   localparam int SET_W = $clog2(SETTLE + 1);

   logic [1:0]       sel_q;
   logic [WD_W-1:0]  wd_q;
   logic [WD_W-1:0]  lim;
   logic [SET_W-1:0] set_q;
   logic             commit;

   assign lim    = long_to_i ? WD_W'(2 * SEL_TO) : WD_W'(SEL_TO);
   assign commit = (sel_i == sel_q) && (wd_q == lim) && (sel_eff_o != sel_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q     <= 2'b00;
         wd_q      <= '0;
         sel_eff_o <= 2'b00;
      end else begin
         sel_q <= sel_i;
         if (sel_i != sel_q)  wd_q <= '0;
         else if (wd_q != lim) wd_q <= wd_q + 1'b1;
         if (commit) sel_eff_o <= sel_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 set_q <= '0;
      else if (commit || reprog_i) set_q <= SET_W'(SETTLE);
      else if (set_q != '0)        set_q <= set_q - 1'b1;
   end

   assign settling_o = (set_q != '0);
endmodule

// File: rtl/vclk_glitch_switch.sv
module vclk_glitch_switch
   import vclk_sel_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [LIVE_N-1:0] lvl_i,
   input  src_e              tgt_i,
   output logic              out_o,
   output logic              wait_o
);
   src_e cur_q;
   logic lv_cur, lv_tgt, rdy_cur, rdy_tgt;

   function automatic logic level_of(input src_e s, input logic [LIVE_N-1:0] l);
      case (s)
         SRC_HIGH: level_of = 1'b1;
         SRC_OFF:  level_of = 1'b0;
         default:  level_of = l[s];
      endcase
   endfunction

   // Constant sources never block the handshake.
   function automatic logic ready_of(input src_e s, input logic [LIVE_N-1:0] l);
      if (s == SRC_HIGH || s == SRC_OFF) ready_of = 1'b1;
      else                               ready_of = l[s];
   endfunction

   assign lv_cur  = level_of(cur_q, lvl_i);
   assign lv_tgt  = level_of(tgt_i, lvl_i);
   assign rdy_cur = ready_of(cur_q, lvl_i);
   assign rdy_tgt = ready_of(tgt_i, lvl_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q  <= SRC_HIGH;
         wait_o <= 1'b0;
         out_o  <= 1'b1;
      end else if (!wait_o) begin
         if (tgt_i != cur_q && rdy_cur) begin
            wait_o <= 1'b1;
            out_o  <= 1'b1;
         end else begin
            out_o  <= lv_cur;
         end
      end else if (rdy_tgt) begin
         cur_q  <= tgt_i;
         wait_o <= 1'b0;
         out_o  <= lv_tgt;
      end else begin
         out_o  <= 1'b1;
      end
   end
endmodule

// File: rtl/vclk_selector.sv
module vclk_selector
   import vclk_sel_pkg::*;
#(
   parameter int SEL_TO = 16,
   parameter int SETTLE = 40,
   parameter int IDX_W  = 4,
   parameter int SYNC_N = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             oe_i,
   input  logic             pd_ni,
   input  logic [1:0]       sel_i,
   input  logic             ext_sel_i,
   input  logic             fb_mem_i,
   input  logic             long_to_i,
   input  logic             reprog_i,
   input  logic [IDX_W-1:0] idx0_i,
   input  logic [IDX_W-1:0] idx1_i,
   input  logic [IDX_W-1:0] idx2_i,
   input  logic [2:0]       reg_clk_i,
   input  logic             ext_clk_i,
   input  logic             ref_clk_i,
   input  logic             mem_clk_i,
   output logic             vclk_o,
   output logic             vclk_en_o
);
   localparam logic [IDX_W-1:0] IDX_MEM = {IDX_W{1'b1}};
   localparam logic [IDX_W-1:0] IDX_OFF = {IDX_W{1'b1}} - 1'b1;

   if (SEL_TO < 1) begin : g_bad_to
      $error("SEL_TO must be at least 1");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end
   if (IDX_W < 2) begin : g_bad_idx
      $error("IDX_W must be at least 2");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   logic [1:0]        sel_eff;
   logic              settling;
   logic              in_wait;
   logic [LIVE_N-1:0] raw_lvl, syn_lvl;
   src_e              tgt;

   assign raw_lvl = {mem_clk_i, ref_clk_i, ext_clk_i, reg_clk_i};

   vclk_sel_qual #(.SEL_TO(SEL_TO), .SETTLE(SETTLE)) u_qual (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel_i),
      .long_to_i  (long_to_i),
      .reprog_i   (reprog_i),
      .sel_eff_o  (sel_eff),
      .settling_o (settling)
   );

   vclk_src_sync #(.N(LIVE_N), .STAGES(SYNC_N)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_lvl),
      .q_o    (syn_lvl)
   );

   function automatic src_e reg_pick(input src_e r, input logic [IDX_W-1:0] idx);
      if (idx == IDX_OFF)      reg_pick = SRC_OFF;
      else if (idx == IDX_MEM) reg_pick = SRC_MEM;
      else                     reg_pick = r;
   endfunction

   always_comb begin
      if (!pd_ni)        tgt = SRC_HIGH;
      else if (settling) tgt = fb_mem_i ? SRC_MEM : SRC_REF;
      else begin
         case (sel_eff)
            2'b00:   tgt = reg_pick(SRC_R0, idx0_i);
            2'b01:   tgt = reg_pick(SRC_R1, idx1_i);
            2'b10:   tgt = ext_sel_i ? reg_pick(SRC_R2, idx2_i) : SRC_EXT;
            default: tgt = reg_pick(SRC_R2, idx2_i);
         endcase
      end
   end

   vclk_glitch_switch u_sw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (syn_lvl),
      .tgt_i  (tgt),
      .out_o  (vclk_o),
      .wait_o (in_wait)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vclk_en_o <= 1'b0;
      else         vclk_en_o <= oe_i;
   end
endmodule

// File: rtl/vclk_sel_chk.sv
module vclk_sel_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       oe_i,
   input logic [1:0] sel_i,
   input logic       vclk_o,
   input logic       vclk_en_o,
   input logic       in_wait,
   input logic [1:0] sel_eff,
   input logic       settling
);
   a_r1_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_i |=> !vclk_en_o);
   a_r1_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_i |=> vclk_en_o);
   a_r4_commit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $changed(sel_eff) |-> sel_eff == $past(sel_i));
   a_r5_settle_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $changed(sel_eff) |-> settling);
   a_r7_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_wait |-> vclk_o);
   a_r7_fall_following: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(vclk_o) |-> !in_wait);
endmodule

bind vclk_selector vclk_sel_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .oe_i      (oe_i),
   .sel_i     (sel_i),
   .vclk_o    (vclk_o),
   .vclk_en_o (vclk_en_o),
   .in_wait   (in_wait),
   .sel_eff   (sel_eff),
   .settling  (settling)
);

// File: tb/sim_vclk_selector.sv
module sim_vclk_selector;
   localparam int TO = 16;
   localparam int ST = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oe = 1'b0, pd_n = 1'b1, ext_sel = 1'b0, fb_mem = 1'b0;
   logic       long_to = 1'b0, reprog = 1'b0;
   logic [1:0] sel = 2'b00;
   logic [3:0] idx0 = 4'h0, idx1 = 4'h3, idx2 = 4'h5;
   logic [5:0] srcs = '0;
   logic       vclk, vclk_en;

   int n_chk = 0, n_bad = 0;
   string req = "R9";

   always #2 clk = ~clk;

   vclk_selector #(.SEL_TO(TO), .SETTLE(ST), .IDX_W(4), .SYNC_N(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .oe_i(oe), .pd_ni(pd_n), .sel_i(sel),
      .ext_sel_i(ext_sel), .fb_mem_i(fb_mem), .long_to_i(long_to),
      .reprog_i(reprog), .idx0_i(idx0), .idx1_i(idx1), .idx2_i(idx2),
      .reg_clk_i(srcs[2:0]), .ext_clk_i(srcs[3]), .ref_clk_i(srcs[4]),
      .mem_clk_i(srcs[5]), .vclk_o(vclk), .vclk_en_o(vclk_en)
   );

   // Source waveforms: half periods per source, changed away from the edge.
   int cyc = 0;
   int half[6] = '{2, 3, 5, 4, 7, 6};
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < 6; i++) srcs[i] <= ((cyc / half[i]) % 2) != 0;
   end

   // Behavioural reference: codes 0..5 live, 6 high, 7 off.
   int m_selq, m_wd, m_sele, m_set, m_cur, m_out, m_en;
   bit m_wait;
   int m_s1[6], m_s2[6];

   function automatic int pick(int r, logic [3:0] ix);
      if (ix == 4'hE) return 7;
      if (ix == 4'hF) return 5;
      return r;
   endfunction

   function automatic int m_tgt();
      if (!pd_n) return 6;
      if (m_set > 0) return fb_mem ? 5 : 4;
      if (m_sele == 0) return pick(0, idx0);
      if (m_sele == 1) return pick(1, idx1);
      if (m_sele == 2 && !ext_sel) return 3;
      return pick(2, idx2);
   endfunction

   function automatic int lvl(int s);
      if (s == 6) return 1;
      if (s == 7) return 0;
      return m_s2[s];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_selq = 0; m_wd = 0; m_sele = 0; m_set = 0;
         m_cur = 6; m_wait = 0; m_out = 1; m_en = 0;
         for (int i = 0; i < 6; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
      end else begin
         int t, lim;
         bit commit;
         t = m_tgt();
         if (!m_wait) begin
            if (t != m_cur && (m_cur >= 6 || lvl(m_cur) == 1)) begin
               m_wait = 1; m_out = 1;
            end else m_out = lvl(m_cur);
         end else if (t >= 6 || lvl(t) == 1) begin
            m_cur = t; m_wait = 0; m_out = lvl(t);
         end else m_out = 1;
         for (int i = 0; i < 6; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = srcs[i]; end
         lim = long_to ? 2 * TO : TO;
         commit = 0;
         if (int'(sel) != m_selq) m_wd = 0;
         else if (m_wd != lim) m_wd++;
         else if (m_sele != m_selq) begin m_sele = m_selq; commit = 1; end
         m_selq = int'(sel);
         if (commit || reprog) m_set = ST;
         else if (m_set > 0) m_set--;
         m_en = oe;
      end
   end

   task automatic check(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp, cyc);
      end
   endtask

   // Per-cycle comparison against the reference, tagged with the active scenario.
   bit run_cmp = 0;
   always @(negedge clk) if (run_cmp) begin
      check({req, " out"}, int'(vclk), m_out);
      check("R1 en", int'(vclk_en), m_en);
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cycles(3);
      check("R9 en after reset", int'(vclk_en), 0);
      check("R9 out after reset", int'(vclk), 1);
      rst_n = 1'b1;
      run_cmp = 1;
      req = "R8"; oe = 1'b1; cycles(100);
      check("R1 enable driven", int'(vclk_en), 1);
      req = "R3"; sel = 2'b01; cycles(150);
      req = "R3"; sel = 2'b10; cycles(150);
      ext_sel = 1'b1; cycles(80);
      req = "R4"; sel = 2'b00; cycles(5); sel = 2'b10; cycles(60);
      req = "R4"; long_to = 1'b1; fb_mem = 1'b1; sel = 2'b11; cycles(150);
      req = "R5"; reprog = 1'b1; cycles(1); reprog = 1'b0; cycles(100);
      req = "R6"; idx2 = 4'hE; cycles(60);
      check("R6 off level", int'(vclk), 0);
      idx2 = 4'hF; cycles(80);
      req = "R2"; pd_n = 1'b0; cycles(60);
      check("R2 forced high", int'(vclk), 1);
      pd_n = 1'b1; req = "R7"; cycles(80);
      oe = 1'b0; cycles(2);
      check("R1 floated", int'(vclk_en), 0);
      run_cmp = 0;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #40000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule